// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits at the dispatch point of a two-wide in-order core. Every cycle it looks at two decoded instruction class codes, the older one and the younger one, each with a valid bit. It decides whether both issue, only the older one issues, or neither issues. It also names the execution resource each issued instruction goes to: integer pipe A, integer pipe B, or one of three floating-point units (add, multiply, divide/square root). The decision and the unit selects are combinational from the current inputs and from one small piece of state.

That state is a count of the cycles during which the shared cache port is still held by a store that issued earlier. An integer store keeps the port for one cycle after its issue. A floating-point store keeps it for two. Any memory instruction that needs the port while it is held must wait. The block checks structural resources only. Register dependencies and long-latency unit occupancy are handled elsewhere.

Top module: `dual_issue_pair_chk`

## Requirements
- R1: Class codes 12 (conditional move), 13 (atomic), 14 (multi-op) and every undefined code 15 to 31 issue alone. In the older slot such a class issues with unit code 6 (whole machine) and the younger slot does not issue. In the younger slot such a class never issues.
- R2: A branch (class 8) issues on pipe B (unit code 2). When the older instruction is an issued branch, the younger one does not issue in that cycle.
- R3: A shift (class 1) is only placed on pipe A (unit code 1). Two shifts never issue together.
- R4: Pipe B serves one instruction per cycle. Multiply/divide (class 7) and branch (class 8) use only pipe B, so two of them never pair.
- R5: A plain integer operation (class 0) may use either pipe. The older one takes pipe A unless the younger issued instruction needs pipe A, in which case it takes pipe B. A younger class-0 instruction takes whichever pipe the older one left free.
- R6: FP add (class 9, unit 3), FP multiply (class 10, unit 4) and FP divide/sqrt (class 11, unit 5) use the single FP arithmetic slot, so at most one of them issues per cycle. Each pairs with integer work.
- R7: Integer load (2), integer store (3), FP load (4), FP store (5) and register-file transfer (6) all use pipe A address generation, so two of them never issue together. Each pairs with FP arithmetic.
- R8: After an integer store issues, the cache port is held for the next cycle. A class 2 to 5 instruction does not issue in that cycle.
- R9: After an FP store issues, the cache port is held for the next two cycles.
- R10: The younger instruction issues only if the older one issues. A slot that does not issue, or whose valid bit is low, reports unit code 0.
- R11: `stall` is high exactly when the older slot is valid and does not issue. issue_count equals the number of issued slots.
- R12: After reset the cache port is free, and with no valid input the outputs are count 0, units 0 and stall 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| old_vld | input | 1 | Older slot holds an instruction |
| old_cls | input | 5 | Older instruction class code |
| yng_vld | input | 1 | Younger slot holds an instruction |
| yng_cls | input | 5 | Younger instruction class code |
| issue_count | output | 2 | Number of instructions issued this cycle |
| old_unit | output | 3 | Unit selected for the older slot |
| yng_unit | output | 3 | Unit selected for the younger slot |
| stall | output | 1 | Older valid instruction held back |

## Verification
Every ordered pair of the 32 class codes is applied with both slots valid. This separates the pipe-A, pipe-B and FP exclusion rules from the solo and branch rules, and it reaches the undefined codes. Directed sequences of a store or FP store followed by memory instructions show the one-cycle and two-cycle port holds, and show that a port-blocked younger load does not pair. A long run of random classes with random valid bits mixes held-port states with all pair types. It also covers the cases of an invalid older slot and of a younger valid instruction behind it.

// File: rtl/dip_pkg.sv
package dip_pkg;

    localparam int unsigned CLS_W  = 5;
    localparam int unsigned UNIT_W = 3;
    localparam int unsigned SLOTS  = 2;

    typedef enum logic [CLS_W-1:0] {
        CL_ALU    = 5'd0,
        CL_SHIFT  = 5'd1,
        CL_LOAD   = 5'd2,
        CL_STORE  = 5'd3,
        CL_FLOAD  = 5'd4,
        CL_FSTORE = 5'd5,
        CL_XFER   = 5'd6,
        CL_IMD    = 5'd7,
        CL_BRANCH = 5'd8,
        CL_FADD   = 5'd9,
        CL_FMUL   = 5'd10,
        CL_FDIV   = 5'd11,
        CL_CMOV   = 5'd12,
        CL_ATOMIC = 5'd13,
        CL_MULTI  = 5'd14
    } icls_e;

    typedef enum logic [UNIT_W-1:0] {
        UNIT_NONE = 3'd0,
        UNIT_IPA  = 3'd1,
        UNIT_IPB  = 3'd2,
        UNIT_FADD = 3'd3,
        UNIT_FMUL = 3'd4,
        UNIT_FDIV = 3'd5,
        UNIT_ALL  = 3'd6
    } unit_e;

    typedef enum logic [1:0] {
        SK_NONE = 2'd0,
        SK_INT  = 2'd1,
        SK_FP   = 2'd2
    } st_kind_e;

    // Resource needs of one decoded slot
    typedef struct packed {
        logic     solo;
        logic     brn;
        logic     need_a;
        logic     need_b;
        logic     flex;
        logic     fp;
        unit_e    fp_unit;
        logic     cache;
        st_kind_e st_kind;
    } need_t;

    function automatic logic is_cache_cls(input logic [CLS_W-1:0] c);
        return (c >= CL_LOAD) && (c <= CL_FSTORE);
    endfunction

endpackage

// File: rtl/dip_decode.sv
module dip_decode
    import dip_pkg::*;
(
    input  logic [CLS_W-1:0] cls_i,
    output need_t            need_o
);
    always_comb begin
        need_o         = '0;
        need_o.fp_unit = UNIT_NONE;
        need_o.st_kind = SK_NONE;
        case (cls_i)
            CL_ALU:             need_o.flex = 1'b1;
            CL_SHIFT, CL_XFER:  need_o.need_a = 1'b1;
            CL_LOAD, CL_FLOAD: begin
                need_o.need_a = 1'b1;
                need_o.cache  = 1'b1;
            end
            CL_STORE: begin
                need_o.need_a  = 1'b1;
                need_o.cache   = 1'b1;
                need_o.st_kind = SK_INT;
            end
            CL_FSTORE: begin
                need_o.need_a  = 1'b1;
                need_o.cache   = 1'b1;
                need_o.st_kind = SK_FP;
            end
            CL_IMD:             need_o.need_b = 1'b1;
            CL_BRANCH: begin
                need_o.need_b = 1'b1;
                need_o.brn    = 1'b1;
            end
            CL_FADD: begin
                need_o.fp      = 1'b1;
                need_o.fp_unit = UNIT_FADD;
            end
            CL_FMUL: begin
                need_o.fp      = 1'b1;
                need_o.fp_unit = UNIT_FMUL;
            end
            CL_FDIV: begin
                need_o.fp      = 1'b1;
                need_o.fp_unit = UNIT_FDIV;
            end
            default:            need_o.solo = 1'b1;
        endcase
    end
endmodule

// File: rtl/dip_cache_port.sv
module dip_cache_port
    import dip_pkg::*;
#(
    parameter int unsigned ST_HOLD  = 1,
    parameter int unsigned FST_HOLD = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  st_kind_e st_kind_i,
    output logic     busy_o
);
    localparam int unsigned HMAX  = (ST_HOLD > FST_HOLD) ? ST_HOLD : FST_HOLD;
    localparam int unsigned CNT_W = (HMAX < 1) ? 1 : $clog2(HMAX + 1);

    logic [CNT_W-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
        end else if (st_kind_i == SK_INT) begin
            hold_cnt <= CNT_W'(ST_HOLD);
        end else if (st_kind_i == SK_FP) begin
            hold_cnt <= CNT_W'(FST_HOLD);
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign busy_o = (hold_cnt != '0);
endmodule

// File: rtl/dip_pair.sv
module dip_pair
    import dip_pkg::*;
(
    input  logic     old_vld_i,
    input  logic     yng_vld_i,
    input  need_t    nd_o,
    input  need_t    nd_y,
    input  logic     port_busy_i,
    output logic     iss_old_o,
    output logic     iss_yng_o,
    output unit_e    unit_old_o,
    output unit_e    unit_yng_o,
    output st_kind_e st_kind_o
);
    logic [1:0] cnt_a, cnt_b, cnt_f;
    logic [2:0] cnt_int;
    logic       fits;

    always_comb begin
        cnt_a   = {1'b0, nd_o.need_a} + {1'b0, nd_y.need_a};
        cnt_b   = {1'b0, nd_o.need_b} + {1'b0, nd_y.need_b};
        cnt_f   = {1'b0, nd_o.flex}   + {1'b0, nd_y.flex};
        cnt_int = {1'b0, cnt_a} + {1'b0, cnt_b} + {1'b0, cnt_f};
        fits    = !(nd_o.fp && nd_y.fp) && (cnt_a <= 2'd1) &&
                  (cnt_b <= 2'd1) && (cnt_int <= 3'd2);

        iss_old_o = old_vld_i && !(nd_o.cache && port_busy_i);
        iss_yng_o = yng_vld_i && iss_old_o && !nd_o.solo && !nd_o.brn &&
                    !nd_y.solo && !(nd_y.cache && port_busy_i) && fits;

        if (!iss_old_o)       unit_old_o = UNIT_NONE;
        else if (nd_o.solo)   unit_old_o = UNIT_ALL;
        else if (nd_o.fp)     unit_old_o = nd_o.fp_unit;
        else if (nd_o.need_a) unit_old_o = UNIT_IPA;
        else if (nd_o.need_b) unit_old_o = UNIT_IPB;
        else                  unit_old_o = (iss_yng_o && nd_y.need_a) ? UNIT_IPB : UNIT_IPA;

        if (!iss_yng_o)       unit_yng_o = UNIT_NONE;
        else if (nd_y.fp)     unit_yng_o = nd_y.fp_unit;
        else if (nd_y.need_a) unit_yng_o = UNIT_IPA;
        else if (nd_y.need_b) unit_yng_o = UNIT_IPB;
        else                  unit_yng_o = (unit_old_o == UNIT_IPA) ? UNIT_IPB : UNIT_IPA;

        if (iss_old_o && nd_o.st_kind != SK_NONE)      st_kind_o = nd_o.st_kind;
        else if (iss_yng_o)                            st_kind_o = nd_y.st_kind;
        else                                           st_kind_o = SK_NONE;
    end
endmodule

// File: rtl/dual_issue_pair_chk.sv
module dual_issue_pair_chk
    import dip_pkg::*;
#(
    parameter int unsigned ST_HOLD  = 1,
    parameter int unsigned FST_HOLD = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             old_vld,
    input  logic [CLS_W-1:0] old_cls,
    input  logic             yng_vld,
    input  logic [CLS_W-1:0] yng_cls,
    output logic [1:0]       issue_count,
    output logic [UNIT_W-1:0] old_unit,
    output logic [UNIT_W-1:0] yng_unit,
    output logic             stall
);
    logic [SLOTS-1:0][CLS_W-1:0] cls_arr;
    need_t    need_arr [SLOTS];
    logic     port_busy, iss_o, iss_y;
    unit_e    u_o, u_y;
    st_kind_e st_kind;

    assign cls_arr[0] = old_cls;
    assign cls_arr[1] = yng_cls;

    for (genvar s = 0; s < SLOTS; s++) begin : g_dec
        dip_decode u_dec (
            .cls_i  (cls_arr[s]),
            .need_o (need_arr[s])
        );
    end

    dip_pair u_pair (
        .old_vld_i   (old_vld),
        .yng_vld_i   (yng_vld),
        .nd_o        (need_arr[0]),
        .nd_y        (need_arr[1]),
        .port_busy_i (port_busy),
        .iss_old_o   (iss_o),
        .iss_yng_o   (iss_y),
        .unit_old_o  (u_o),
        .unit_yng_o  (u_y),
        .st_kind_o   (st_kind)
    );

    dip_cache_port #(
        .ST_HOLD  (ST_HOLD),
        .FST_HOLD (FST_HOLD)
    ) u_port (
        .clk       (clk),
        .rst       (rst),
        .st_kind_i (st_kind),
        .busy_o    (port_busy)
    );

    assign issue_count = {1'b0, iss_o} + {1'b0, iss_y};
    assign old_unit    = u_o;
    assign yng_unit    = u_y;
    assign stall       = old_vld && !iss_o;
endmodule

// File: rtl/dip_chk.sv
module dip_chk
    import dip_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             old_vld,
    input logic [CLS_W-1:0] old_cls,
    input logic             yng_vld,
    input logic [CLS_W-1:0] yng_cls,
    input logic [1:0]       issue_count,
    input logic [UNIT_W-1:0] old_unit,
    input logic [UNIT_W-1:0] yng_unit,
    input logic             stall
);
    logic o_iss, y_iss, st_iss, fst_iss, cache_iss;
    logic o_fp, y_fp;

    assign o_iss     = (old_unit != UNIT_NONE);
    assign y_iss     = (yng_unit != UNIT_NONE);
    assign st_iss    = (o_iss && old_cls == CL_STORE)  || (y_iss && yng_cls == CL_STORE);
    assign fst_iss   = (o_iss && old_cls == CL_FSTORE) || (y_iss && yng_cls == CL_FSTORE);
    assign cache_iss = (o_iss && is_cache_cls(old_cls)) || (y_iss && is_cache_cls(yng_cls));
    assign o_fp      = (old_unit >= UNIT_FADD) && (old_unit <= UNIT_FDIV);
    assign y_fp      = (yng_unit >= UNIT_FADD) && (yng_unit <= UNIT_FDIV);

    a_r1_solo_alone: assert property (@(posedge clk) disable iff (rst)
        (old_unit == UNIT_ALL) |-> (yng_unit == UNIT_NONE && issue_count == 2'd1));

    a_r2_branch_closes: assert property (@(posedge clk) disable iff (rst)
        (o_iss && old_cls == CL_BRANCH) |-> (yng_unit == UNIT_NONE));

    a_r3_one_pipe_a: assert property (@(posedge clk) disable iff (rst)
        !(old_unit == UNIT_IPA && yng_unit == UNIT_IPA));

    a_r4_one_pipe_b: assert property (@(posedge clk) disable iff (rst)
        !(old_unit == UNIT_IPB && yng_unit == UNIT_IPB));

    a_r6_one_fp: assert property (@(posedge clk) disable iff (rst)
        !(o_fp && y_fp));

    a_r8_store_hold: assert property (@(posedge clk) disable iff (rst)
        st_iss |=> !cache_iss);

    a_r9_fstore_hold: assert property (@(posedge clk) disable iff (rst)
        fst_iss |=> !cache_iss ##1 !cache_iss);

    a_r10_in_order: assert property (@(posedge clk) disable iff (rst)
        y_iss |-> o_iss);

    a_r10_invalid_idle: assert property (@(posedge clk) disable iff (rst)
        (!old_vld |-> !o_iss) and (!yng_vld |-> !y_iss));

    a_r11_stall: assert property (@(posedge clk) disable iff (rst)
        stall |-> (issue_count == 2'd0 && old_vld));
endmodule

bind dual_issue_pair_chk dip_chk u_chk (.*);

// File: tb/tb_dual_issue_pair_chk.sv
module tb_dual_issue_pair_chk;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       old_vld = 1'b0, yng_vld = 1'b0;
    logic [4:0] old_cls = '0, yng_cls = '0;
    logic [1:0] issue_count;
    logic [2:0] old_unit, yng_unit;
    logic       stall;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    int m_cnt  = 0;   // bench model of port hold cycles

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_issue_pair_chk dut (
        .clk(clk), .rst(rst),
        .old_vld(old_vld), .old_cls(old_cls),
        .yng_vld(yng_vld), .yng_cls(yng_cls),
        .issue_count(issue_count), .old_unit(old_unit),
        .yng_unit(yng_unit), .stall(stall)
    );

    typedef struct {
        bit       solo;
        bit       brn;
        bit [1:0] pipes;  // bit0 pipe A allowed, bit1 pipe B allowed
        int       fpu;    // 0 none, else unit code 3..5
        bit       mem;
        int       hold;
    } prof_t;

    function automatic prof_t prof(input logic [4:0] c);
        prof_t p = '{0, 0, 2'b00, 0, 0, 0};
        case (c)
            5'd0:  p.pipes = 2'b11;
            5'd1:  p.pipes = 2'b01;
            5'd2:  begin p.pipes = 2'b01; p.mem = 1; end
            5'd3:  begin p.pipes = 2'b01; p.mem = 1; p.hold = 1; end
            5'd4:  begin p.pipes = 2'b01; p.mem = 1; end
            5'd5:  begin p.pipes = 2'b01; p.mem = 1; p.hold = 2; end
            5'd6:  p.pipes = 2'b01;
            5'd7:  p.pipes = 2'b10;
            5'd8:  begin p.pipes = 2'b10; p.brn = 1; end
            5'd9:  p.fpu = 3;
            5'd10: p.fpu = 4;
            5'd11: p.fpu = 5;
            default: p.solo = 1;
        endcase
        return p;
    endfunction

    // Expected {count, unit_old, unit_yng, stall, hold_started}
    task automatic model(input bit ov, input logic [4:0] oc, input bit yv,
                         input logic [4:0] yc, output int e_cnt, output int e_uo,
                         output int e_uy, output bit e_st, output int e_hold);
        prof_t po = prof(oc);
        prof_t py = prof(yc);
        bit busy = (m_cnt != 0);
        bit ok_o = ov && !(po.mem && busy);
        bit found = 0;
        int pa = 0, pb = 0;
        bit ok_y;
        for (int k = 0; k < 2; k++) begin
            for (int m = 0; m < 2; m++) begin
                int ca = (po.pipes == 0) ? 0 : k + 1;
                int cb = (py.pipes == 0) ? 0 : m + 1;
                bit va = (po.pipes == 0) ? (k == 0) : po.pipes[k];
                bit vb = (py.pipes == 0) ? (m == 0) : py.pipes[m];
                if (!found && va && vb && (ca == 0 || ca != cb) &&
                    !(po.fpu != 0 && py.fpu != 0)) begin
                    found = 1; pa = ca; pb = cb;
                end
            end
        end
        ok_y = yv && ok_o && !po.solo && !po.brn && !py.solo &&
               !(py.mem && busy) && found;
        if (!ok_y) pa = (po.pipes[0]) ? 1 : ((po.pipes[1]) ? 2 : 0);
        e_uo = !ok_o ? 0 : po.solo ? 6 : (po.fpu != 0) ? po.fpu : pa;
        e_uy = !ok_y ? 0 : (py.fpu != 0) ? py.fpu : pb;
        e_cnt = int'(ok_o) + int'(ok_y);
        e_st = ov && !ok_o;
        e_hold = ok_o && po.hold != 0 ? po.hold : (ok_y ? py.hold : 0);
    endtask

    function automatic string tag_of(input bit ov, input logic [4:0] oc,
                                     input bit yv, input logic [4:0] yc);
        prof_t po = prof(oc);
        prof_t py = prof(yc);
        if (!ov) return "R10";
        if (po.solo || py.solo) return "R1";
        if (po.brn) return "R2";
        if (m_cnt != 0 && (po.mem || py.mem)) return "R8";
        if (oc == 5'd1 && yc == 5'd1) return "R3";
        if (po.pipes == 2'b10 && py.pipes == 2'b10) return "R4";
        if (po.fpu != 0 || py.fpu != 0) return "R6";
        if (po.mem || py.mem) return "R7";
        if (oc == 5'd0 || yc == 5'd0) return "R5";
        return "R11";
    endfunction

    // Drive at negedge, compare 1 time unit later, advance model with the expectation
    task automatic step(input string tag, input bit ov, input logic [4:0] oc,
                        input bit yv, input logic [4:0] yc);
        int e_cnt, e_uo, e_uy, e_hold;
        bit e_st;
        @(negedge clk);
        old_vld = ov; old_cls = oc; yng_vld = yv; yng_cls = yc;
        #1;
        model(ov, oc, yv, yc, e_cnt, e_uo, e_uy, e_st, e_hold);
        checks++;
        if (int'(issue_count) != e_cnt || int'(old_unit) != e_uo ||
            int'(yng_unit) != e_uy || stall != e_st) begin
            errors++;
            $display("FAIL %s old=%0d/%0d yng=%0d/%0d actual cnt=%0d uo=%0d uy=%0d st=%0b expected cnt=%0d uo=%0d uy=%0d st=%0b",
                     tag, ov, oc, yv, yc, issue_count, old_unit, yng_unit, stall,
                     e_cnt, e_uo, e_uy, e_st);
        end
        if (e_hold != 0) m_cnt = e_hold;
        else if (m_cnt > 0) m_cnt--;
    endtask

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R12: idle outputs after reset
        step("R12", 0, 5'd0, 0, 5'd0);

        // R8: integer store then a load held for one cycle
        step("R8", 1, 5'd3, 0, 5'd0);
        step("R8", 1, 5'd2, 1, 5'd0);
        step("R8", 1, 5'd2, 0, 5'd0);
        // R9: FP store then two blocked cycles
        step("R9", 1, 5'd5, 1, 5'd9);
        step("R9", 1, 5'd4, 0, 5'd0);
        step("R9", 1, 5'd0, 1, 5'd2);
        step("R9", 1, 5'd4, 0, 5'd0);
        // R5: ALU assignment around a shift and another ALU
        step("R5", 1, 5'd0, 1, 5'd1);
        step("R5", 1, 5'd0, 1, 5'd0);
        step("R5", 1, 5'd1, 1, 5'd0);
        // R2: branch closes group; R10: invalid older blocks younger
        step("R2", 1, 5'd8, 1, 5'd0);
        step("R10", 0, 5'd0, 1, 5'd0);
        // R1: undefined code issues alone
        step("R1", 1, 5'd31, 1, 5'd0);
        step("R1", 1, 5'd0, 1, 5'd20);
        // R6/R7: FP arithmetic with FP memory, two FP ops
        step("R7", 1, 5'd9, 1, 5'd4);
        step("R6", 1, 5'd10, 1, 5'd11);

        // All ordered class pairs
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                step(tag_of(1, 5'(a), 1, 5'(b)), 1, 5'(a), 1, 5'(b));
            end
        end

        // Random mix, mostly defined classes
        for (int n = 0; n < 4000; n++) begin
            bit ov = ($urandom % 8) != 0;
            bit yv = ($urandom % 8) != 0;
            logic [4:0] oc = (($urandom % 10) == 0) ? 5'($urandom) : 5'($urandom % 12);
            logic [4:0] yc = (($urandom % 10) == 0) ? 5'($urandom) : 5'($urandom % 12);
            step(tag_of(ov, oc, yv, yc), ov, oc, yv, yc);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule